// File: doc/BRIEF.md
# Vector Bit Gather Permute Unit

This functional unit builds a short bit field by picking single bits out of a 128-bit source vector A. A 128-bit index vector B supplies the picks: every byte of B is one selector naming a bit position of A. Bits are numbered MSB-first: bit 0 is the most significant bit of a vector, and doubleword 0 is its upper 64 bits. A selector that points outside the allowed range yields a zero bit.

Two modes are supported. In quadword mode all 16 selectors address the whole of A, and the 16 picked bits land right-justified in the upper doubleword of the result. In doubleword mode the vector is split into two independent 64-bit lanes; each lane's 8 selectors address only that lane's half of A, and each lane's 8 picked bits land right-justified in that lane's doubleword. Every result bit not written by a pick is zero. When the vector-enable flag is clear, the operation is not performed and an unavailable flag is raised instead.

One operation is accepted per clock. The result is registered once, so it appears on the clock after the strobe and holds until the next accepted operation.

Top module: `bgp_unit`

## Requirements
- R1: In quadword mode (in_mode = 0), for each i from 0 to 15, result bit 48+i equals bit s of A, where s is byte i of B and is below 128 (MSB-first numbering: bit k of a vector is its k-th bit from the most significant end, byte i covers bits 8i to 8i+7).
- R2: In quadword mode, a selector of 128 or more (top selector bit set) yields a zero result bit.
- R3: In quadword mode, result bits 0 to 47 and 64 to 127 are zero.
- R4: In doubleword mode (in_mode = 1), for lane d in {0,1} and j from 0 to 7, bit 56+j of result doubleword d equals bit s of doubleword d of A, where s is byte j of doubleword d of B and is below 64.
- R5: In doubleword mode, a selector of 64 or more, including 128 to 255, yields a zero result bit.
- R6: In doubleword mode, bits 0 to 55 of each result doubleword are zero.
- R7: In doubleword mode, a lane's selectors reach only that lane's source bits; lane 1 never reads doubleword 0 of A and lane 0 never reads doubleword 1.
- R8: An accepted operation with vec_en = 0 sets unavail to 1 and drives result to all zeros; one with vec_en = 1 sets unavail to 0.
- R9: out_valid is in_valid delayed by exactly one clock; result and unavail change only on the clock after an accepted operation and otherwise hold.
- R10: A synchronous active-high reset clears out_valid, unavail and result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 1 | 0 = quadword gather, 1 = two-lane doubleword gather |
| vec_en | input | 1 | Vector enable; clear means the operation is refused |
| src_a | input | 128 | Source vector, MSB-first bit numbering |
| idx_b | input | 128 | Sixteen byte selectors |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 128 | Registered gathered result |
| unavail | output | 1 | Set when the last accepted operation was refused |

## Verification
An ascending selector sequence against a known source separates correct MSB-first numbering from an LSB-first or byte-reversed reading, while an all-ones source with all-zero selectors exposes any stray bit outside the right-justified field. Selector values at 63, 64, 127, 128 and 255 separate the quadword and doubleword range checks, which a design sharing one limit would confuse. A source with only one doubleword set, fed with in-range lane selectors, shows whether a lane leaks into its neighbour, and randomized operands in both modes are compared against a bench model written straight from the bit equations.

// File: rtl/bgp_pkg.sv
package bgp_pkg;

   typedef enum logic {
      GATHER_QUAD = 1'b0,
      GATHER_LANE = 1'b1
   } gather_mode_e;

endpackage

// File: rtl/bgp_bit_pick.sv
module bgp_bit_pick #(
   parameter int SRC_W = 128,
   parameter int SEL_W = 8
) (
   input  logic [SRC_W-1:0] src,
   input  logic [SEL_W-1:0] sel,
   output logic             bit_o
);
   localparam int IDX_W = $clog2(SRC_W);
   localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(SRC_W);

   generate
      if ((1 << IDX_W) != SRC_W) begin : g_bad_width
         $error("bgp_bit_pick: SRC_W must be a power of two");
      end
      if (SEL_W < IDX_W) begin : g_bad_sel
         $error("bgp_bit_pick: SEL_W too narrow to address SRC_W");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   assign idx = sel[IDX_W-1:0];

   // MSB-first numbering: position k lives at vector index SRC_W-1-k, i.e. ~k.
   always_comb begin
      if ({1'b0, sel} < LIMIT) bit_o = src[~idx];
      else                     bit_o = 1'b0;
   end
endmodule

// File: rtl/bgp_gather.sv
module bgp_gather #(
   parameter int SRC_W = 128,
   parameter int NSEL  = 16,
   parameter int SEL_W = 8
) (
   input  logic [SRC_W-1:0]      src,
   input  logic [NSEL*SEL_W-1:0] sels,
   output logic [NSEL-1:0]       bits
);
   generate
      for (genvar j = 0; j < NSEL; j++) begin : g_pick
         // selector j counted from the most significant byte; picked bit j
         // counted from the most significant end of the field
         bgp_bit_pick #(.SRC_W(SRC_W), .SEL_W(SEL_W)) u_pick (
            .src   (src),
            .sel   (sels[(NSEL-1-j)*SEL_W +: SEL_W]),
            .bit_o (bits[NSEL-1-j])
         );
      end
   endgenerate
endmodule

// File: rtl/bgp_unit.sv
module bgp_unit
   import bgp_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int SEL_W = 8,
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_mode,
   input  logic             vec_en,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] idx_b,
   output logic             out_valid,
   output logic [VEC_W-1:0] result,
   output logic             unavail
);
   localparam int NSEL_Q   = VEC_W / SEL_W;
   localparam int LANE_W   = VEC_W / LANES;
   localparam int LANE_SEL = LANE_W / SEL_W;
   localparam int Q_LSB    = VEC_W - LANE_W;

   generate
      if (VEC_W % SEL_W != 0) begin : g_chk_sel
         $error("bgp_unit: VEC_W must be a multiple of SEL_W");
      end
      if (VEC_W % LANES != 0 || LANE_W % SEL_W != 0) begin : g_chk_lane
         $error("bgp_unit: lanes must hold a whole number of selectors");
      end
      if (NSEL_Q > LANE_W) begin : g_chk_fit
         $error("bgp_unit: quadword field does not fit in the upper lane");
      end
   endgenerate

   function automatic logic [VEC_W-1:0] quad_field_mask();
      logic [VEC_W-1:0] m = '0;
      for (int k = 0; k < NSEL_Q; k++) m[Q_LSB + k] = 1'b1;
      return m;
   endfunction

   function automatic logic [VEC_W-1:0] lane_field_mask();
      logic [VEC_W-1:0] m = '0;
      for (int l = 0; l < LANES; l++)
         for (int k = 0; k < LANE_SEL; k++) m[VEC_W - LANE_W*(l+1) + k] = 1'b1;
      return m;
   endfunction

   localparam logic [VEC_W-1:0] QUAD_MASK = quad_field_mask();
   localparam logic [VEC_W-1:0] LANE_MASK = lane_field_mask();

   gather_mode_e mode;
   assign mode = gather_mode_e'(in_mode);

   // quadword datapath: all selectors over the whole source
   logic [NSEL_Q-1:0] quad_bits;
   bgp_gather #(.SRC_W(VEC_W), .NSEL(NSEL_Q), .SEL_W(SEL_W)) u_quad (
      .src  (src_a),
      .sels (idx_b),
      .bits (quad_bits)
   );

   // doubleword datapath: one gather per lane, confined to its own half
   logic [VEC_W-1:0] lane_res;
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         localparam int BASE = VEC_W - LANE_W*(l+1);
         logic [LANE_SEL-1:0] lbits;
         bgp_gather #(.SRC_W(LANE_W), .NSEL(LANE_SEL), .SEL_W(SEL_W)) u_lane (
            .src  (src_a[BASE +: LANE_W]),
            .sels (idx_b[BASE + LANE_W - LANE_SEL*SEL_W +: LANE_SEL*SEL_W]),
            .bits (lbits)
         );
         assign lane_res[BASE +: LANE_W] = {{(LANE_W-LANE_SEL){1'b0}}, lbits};
      end
   endgenerate

   logic [VEC_W-1:0] next_res;
   always_comb begin
      next_res = '0;
      if (vec_en) begin
         if (mode == GATHER_QUAD) next_res[Q_LSB +: NSEL_Q] = quad_bits;
         else                     next_res = lane_res;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
         unavail   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= next_res;
            unavail <= ~vec_en;
         end
      end
   end

   AST_QUAD_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_mode == 1'b0 |=> (result & ~QUAD_MASK) == '0)
      else $error("AST_QUAD_ZERO_FILL"); // R3
   AST_LANE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_mode == 1'b1 |=> (result & ~LANE_MASK) == '0)
      else $error("AST_LANE_ZERO_FILL"); // R6
   AST_REFUSED_OP: assert property (@(posedge clk) disable iff (rst)
      in_valid && !vec_en |=> unavail && result == '0)
      else $error("AST_REFUSED_OP"); // R8
   AST_ACCEPTED_OP: assert property (@(posedge clk) disable iff (rst)
      in_valid && vec_en |=> !unavail)
      else $error("AST_ACCEPTED_OP"); // R8
   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> out_valid == $past(in_valid))
      else $error("AST_VALID_DELAY"); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result) && $stable(unavail))
      else $error("AST_IDLE_HOLD"); // R9
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> !out_valid && !unavail && result == '0)
      else $error("AST_RESET_CLEAR"); // R10
endmodule

// File: tb/bgp_unit_test.sv
module bgp_unit_test;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic         in_mode;
   logic         vec_en;
   logic [127:0] src_a;
   logic [127:0] idx_b;
   logic         out_valid;
   logic [127:0] result;
   logic         unavail;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   bgp_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
      .vec_en(vec_en), .src_a(src_a), .idx_b(idx_b),
      .out_valid(out_valid), .result(result), .unavail(unavail)
   );

   // model straight from the MSB-first bit equations
   function automatic logic [127:0] model(input logic mode, input logic en,
                                          input logic [127:0] a,
                                          input logic [127:0] b);
      logic [127:0] r = '0;
      if (!en) return r;
      if (!mode) begin
         for (int i = 0; i < 16; i++) begin
            int s = int'(b[127-8*i -: 8]);
            if (s < 128) r[127-(48+i)] = a[127-s];
         end
      end else begin
         for (int d = 0; d < 2; d++)
            for (int j = 0; j < 8; j++) begin
               int s = int'(b[127-64*d-8*j -: 8]);
               if (s < 64) r[127-64*d-(56+j)] = a[127-64*d-s];
            end
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %032h expected %032h", req, act, exp);
      end
   endtask

   // issue one operation, check the registered outputs, then check one idle hold
   task automatic run_op(input string req, input logic mode, input logic en,
                         input logic [127:0] a, input logic [127:0] b);
      logic [127:0] exp;
      exp = model(mode, en, a, b);
      @(negedge clk);
      in_valid = 1'b1; in_mode = mode; vec_en = en; src_a = a; idx_b = b;
      @(negedge clk);
      in_valid = 1'b0; src_a = ~a; idx_b = ~b; vec_en = ~en;
      chk({req, " result"}, result, exp);
      chk("R9 out_valid high", {127'b0, out_valid}, 128'd1);
      chk("R8 unavail", {127'b0, unavail}, {127'b0, ~en});
      @(negedge clk);
      chk("R9 out_valid low", {127'b0, out_valid}, 128'd0);
      chk("R9 result hold", result, exp);
   endtask

   function automatic logic [127:0] fill_bytes(input logic [7:0] v);
      return {16{v}};
   endfunction

   task automatic t_reset();
      chk("R10 reset result", result, '0);
      chk("R10 reset out_valid", {127'b0, out_valid}, '0);
      chk("R10 reset unavail", {127'b0, unavail}, '0);
   endtask

   task automatic t_quad_identity();
      logic [127:0] b;
      for (int i = 0; i < 16; i++) b[127-8*i -: 8] = 8'(i);
      run_op("R1 ascending", 1'b0, 1'b1, 128'hA5C3_0000_0000_0000_0000_0000_0000_0000, b);
      chk("R1 ascending field", result, {48'b0, 16'hA5C3, 64'b0});
      for (int i = 0; i < 16; i++) b[127-8*i -: 8] = 8'(127 - i);
      run_op("R1 tail picks", 1'b0, 1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_8001, b);
      chk("R1 tail field", result, {48'b0, 16'h8001, 64'b0});
   endtask

   task automatic t_quad_range();
      logic [127:0] b;
      b = fill_bytes(8'h80);
      run_op("R2 all 128", 1'b0, 1'b1, '1, b);
      chk("R2 all 128 zero", result, '0);
      b = {8'd127, 8'd128, 8'd255, 8'd0, 8'd200, {11{8'd64}}};
      run_op("R2 mixed", 1'b0, 1'b1, '1, b);
      chk("R2 mixed field", result, {48'b0, 16'b1001_0111_1111_1111, 64'b0});
      run_op("R3 zero fill", 1'b0, 1'b1, '1, '0);
      chk("R3 zero fill field", result, {48'b0, 16'hFFFF, 64'b0});
   endtask

   task automatic t_lane();
      logic [127:0] b;
      for (int j = 0; j < 8; j++) begin
         b[127-8*j -: 8] = 8'(j);
         b[63-8*j  -: 8] = 8'(63 - j);
      end
      run_op("R4 lanes", 1'b1, 1'b1, 128'hB400_0000_0000_0000_0000_0000_0000_0029, b);
      chk("R4 lane fields", result, {56'b0, 8'hB4, 56'b0, 8'h94});
      b = {8'd63, 8'd64, 8'd128, 8'd255, 8'd100, 8'd0, 8'd65, 8'd191,
           8'd64, 8'd63, 8'd127, 8'd0, 8'd240, 8'd32, 8'd129, 8'd1};
      run_op("R5 lane range", 1'b1, 1'b1, '1, b);
      chk("R5 lane range fields", result, {56'b0, 8'b1000_0100, 56'b0, 8'b0101_0101});
      run_op("R6 lane zero fill", 1'b1, 1'b1, '1, '0);
      chk("R6 lane zero fill", result, {56'b0, 8'hFF, 56'b0, 8'hFF});
      for (int j = 0; j < 16; j++) b[127-8*j -: 8] = 8'(j % 8);
      run_op("R7 lane isolation upper", 1'b1, 1'b1, {64'hFF00_0000_0000_0000, 64'h0}, b);
      chk("R7 lane 1 no leak", result, {56'b0, 8'hFF, 64'b0});
      run_op("R7 lane isolation lower", 1'b1, 1'b1, {64'h0, 64'hFF00_0000_0000_0000}, b);
      chk("R7 lane 0 no leak", result, {64'b0, 56'b0, 8'hFF});
   endtask

   task automatic t_unavail();
      run_op("R8 refused", 1'b0, 1'b0, '1, '0);
      chk("R8 refused zero", result, '0);
      chk("R8 refused flag", {127'b0, unavail}, 128'd1);
      run_op("R8 refused lane", 1'b1, 1'b0, '1, '0);
      run_op("R8 enabled again", 1'b0, 1'b1, '1, '0);
      chk("R8 flag cleared", {127'b0, unavail}, 128'd0);
   endtask

   task automatic t_hold_and_reset();
      logic [127:0] keep;
      run_op("R9 setup", 1'b1, 1'b1, '1, '0);
      keep = result;
      repeat (5) @(negedge clk);
      chk("R9 long idle hold", result, keep);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R10 mid-run reset result", result, '0);
      chk("R10 mid-run reset unavail", {127'b0, unavail}, '0);
   endtask

   task automatic t_random();
      for (int n = 0; n < 40; n++) begin
         logic [127:0] a, b;
         logic m;
         a = {$urandom, $urandom, $urandom, $urandom};
         b = {$urandom, $urandom, $urandom, $urandom};
         m = n[0];
         if (n % 4 < 2) for (int k = 0; k < 16; k++) b[8*k+7] = 1'b0;
         run_op(m ? "R4 random lanes" : "R1 random quad", m, 1'b1, a, b);
      end
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; vec_en = 1'b1;
      src_a = '0; idx_b = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_quad_identity();
      t_quad_range();
      t_lane();
      t_unavail();
      t_hold_and_reset();
      t_random();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule